// File: doc/BRIEF.md
# CAN Acceptance Filter Bank Array

This block decides, for each received CAN frame, whether the frame is kept. If it is kept, the block also chooses which of two receive FIFOs takes it and which filter matched. A receive engine presents the frame's identifier, extended flag and remote flag with a one-cycle strobe. One clock later the block returns a single-cycle result carrying accept, the FIFO index and the number of the winning filter.

The block holds a parameterised number of filter banks, each with two 32-bit registers. In list mode a bank holds two exact-match identifiers. In mask mode it holds one identifier and a care mask. Mode, scale, FIFO routing and activation are set per bank, not per identifier. An activated bank takes part in matching whatever its registers hold, so software must activate exactly the banks it has filled.

Configuration goes through a simple register-write port. Bank contents and the mode, scale and routing masks change only while the init flag is set, and matching is suspended while that flag is set.

Top module: `can_accept_filter`

## Requirements
- R1: The comparison word places a standard 11-bit identifier in bits 31:21 with bits 20:3 zero, or a 29-bit extended identifier in bits 31:3. Bit 2 is the extended flag, bit 1 is the remote flag and bit 0 is zero. Every bit of the word takes part in comparison.
- R2: In list mode (mode bit 0), bank b gives filter 2b, which matches when the word equals register 0, and filter 2b+1, which matches when the word equals register 1.
- R3: In mask mode (mode bit 1), bank b gives filter 2b. It matches when the word agrees with register 0 in every bit that is set in register 1.
- R4: A bank whose activation bit is clear never matches. An active bank matches on whatever its registers hold. The activation mask (address 4) can be written whether or not init is set.
- R5: Only banks whose scale bit is 1 (32-bit scale) match. A bank with scale bit 0 never accepts.
- R6: When several filters match, the lowest filter number wins. The FIFO index reported is the routing bit of that filter's bank.
- R7: Address 0 bit 0 is the init flag and can always be written. Address 1 is the mode mask, address 2 the scale mask and address 3 the FIFO mask, one bit per bank. Address 32+2b+r is register r of bank b. Writes to addresses 1 to 3 and to the bank registers take effect only while init is set, and are ignored otherwise.
- R8: While init is set, a strobed frame produces a result pulse with accept low.
- R9: result_valid goes high exactly one cycle after frame_valid and stays high for that one cycle. On a reject, the FIFO index and the filter number read zero.
- R10: After reset every register is zero, all banks are inactive and init is clear, so every frame is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| frame_valid | input | 1 | Frame identifier strobe |
| frame_id | input | 29 | Identifier; standard frames use bits 10:0 |
| frame_ext | input | 1 | Extended identifier flag |
| frame_rtr | input | 1 | Remote frame flag |
| result_valid | output | 1 | Decision pulse, one cycle after the strobe |
| result_accept | output | 1 | Frame accepted |
| result_fifo | output | 1 | Target FIFO of the winning filter |
| result_filter | output | IDX_W | Number of the winning filter |

## Verification
A vector table strobes standard and extended identifiers at one fixed configuration. Exact hits in list mode separate the two filters of a bank. Frames that differ only in the remote or extended flag show that those bits are compared. Identifiers whose top eleven bits alias a standard identifier show that the standard and extended layouts are kept apart. Masked ranges with one care bit flipped confirm that mask mode ignores don't-care bits. Directed runs then check the remaining cases: a filled but inactive bank, a 32-bit-scale bank switched off, overlapping catch-all and exact filters for priority, writes issued outside init, and a frame strobed during init.

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int NUM_BANKS = 14,
  parameter int ADDR_W    = 8,
  localparam int NUM_FILT = 2 * NUM_BANKS,
  localparam int IDX_W    = $clog2(NUM_FILT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              frame_valid,
  input  logic [28:0]       frame_id,
  input  logic              frame_ext,
  input  logic              frame_rtr,
  output logic              result_valid,
  output logic              result_accept,
  output logic              result_fifo,
  output logic [IDX_W-1:0]  result_filter
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SCALE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FIFO  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ACT   = ADDR_W'(4);
  localparam int REG_BASE = 32;

  logic                 init_q;
  logic [NUM_BANKS-1:0] mode_q, scale_q, fifo_q, act_q;
  logic [31:0]          fr_q [NUM_BANKS][2];
  logic [NUM_FILT-1:0]  hit;
  logic [31:0]          cmp_word;
  logic                 cfg_ok;
  logic                 any_hit;
  logic                 pick_fifo;
  logic [IDX_W-1:0]     pick_idx;

  assign cfg_ok = cfg_we & init_q;

  assign cmp_word = frame_ext ? {frame_id, 1'b1, frame_rtr, 1'b0}
                              : {frame_id[10:0], 18'd0, 1'b0, frame_rtr, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= 1'b0;
      mode_q  <= '0;
      scale_q <= '0;
      fifo_q  <= '0;
      act_q   <= '0;
    end else begin
      if (cfg_we && cfg_addr == A_CTRL)  init_q  <= cfg_wdata[0];
      if (cfg_we && cfg_addr == A_ACT)   act_q   <= cfg_wdata[NUM_BANKS-1:0];
      if (cfg_ok && cfg_addr == A_MODE)  mode_q  <= cfg_wdata[NUM_BANKS-1:0];
      if (cfg_ok && cfg_addr == A_SCALE) scale_q <= cfg_wdata[NUM_BANKS-1:0];
      if (cfg_ok && cfg_addr == A_FIFO)  fifo_q  <= cfg_wdata[NUM_BANKS-1:0];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar r = 0; r < 2; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) fr_q[b][r] <= '0;
        else if (cfg_ok && cfg_addr == ADDR_W'(REG_BASE + 2*b + r))
          fr_q[b][r] <= cfg_wdata;
      end
    end

    logic live, eq0, eq1, mhit;
    assign live = act_q[b] & scale_q[b];
    assign eq0  = cmp_word == fr_q[b][0];
    assign eq1  = cmp_word == fr_q[b][1];
    assign mhit = ((cmp_word ^ fr_q[b][0]) & fr_q[b][1]) == 32'd0;
    assign hit[2*b]   = live & (mode_q[b] ? mhit : eq0);
    assign hit[2*b+1] = live & ~mode_q[b] & eq1;
  end

  always_comb begin
    any_hit   = 1'b0;
    pick_idx  = '0;
    pick_fifo = 1'b0;
    for (int i = NUM_FILT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit   = 1'b1;
        pick_idx  = IDX_W'(i);
        pick_fifo = fifo_q[i/2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_valid  <= 1'b0;
      result_accept <= 1'b0;
      result_fifo   <= 1'b0;
      result_filter <= '0;
    end else begin
      result_valid  <= frame_valid;
      result_accept <= frame_valid & ~init_q & any_hit;
      result_fifo   <= frame_valid & ~init_q & any_hit & pick_fifo;
      result_filter <= (frame_valid & ~init_q & any_hit) ? pick_idx : '0;
    end
  end

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> result_valid);
  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> !result_valid);
  p_reject_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !result_accept |-> (result_filter == '0 && !result_fifo));
  p_init_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && init_q) |=> !result_accept);
  p_mode_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !init_q && cfg_addr == A_MODE) |=> $stable(mode_q));
  p_fifo_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !init_q && cfg_addr == A_FIFO) |=> $stable(fifo_q));
  p_active_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_accept |-> ((($past(act_q) & $past(scale_q)) >> (result_filter >> 1)) & NUM_BANKS'(1)) != '0);

endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;
  logic clk = 0, rst_n = 0, cfg_we = 0, frame_valid = 0, frame_ext = 0, frame_rtr = 0;
  logic [7:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [28:0] frame_id = 0;
  logic        result_valid, result_accept, result_fifo;
  logic [4:0]  result_filter;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  can_accept_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frame_valid(frame_valid), .frame_id(frame_id), .frame_ext(frame_ext), .frame_rtr(frame_rtr),
    .result_valid(result_valid), .result_accept(result_accept), .result_fifo(result_fifo),
    .result_filter(result_filter));

  // {ext, rtr, id[28:0], accept, fifo, filter[4:0]}
  localparam int NV = 14;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 1'b0, 29'd13,          1'b1, 1'b1, 5'd0},  // R2 first list entry
    {1'b0, 1'b0, 29'd14,          1'b1, 1'b1, 5'd1},  // R2 second list entry
    {1'b0, 1'b0, 29'd15,          1'b0, 1'b0, 5'd0},  // R2 miss
    {1'b0, 1'b1, 29'd13,          1'b0, 1'b0, 5'd0},  // R1 remote flag compared
    {1'b1, 1'b0, 29'd13,          1'b0, 1'b0, 5'd0},  // R1 extended flag compared
    {1'b1, 1'b0, 29'd13 << 18,    1'b0, 1'b0, 5'd0},  // R1 alias in top bits
    {1'b0, 1'b0, 29'h1A5,         1'b1, 1'b0, 5'd2},  // R3 masked range
    {1'b0, 1'b0, 29'h13F,         1'b1, 1'b0, 5'd2},  // R3 other don't-care bits
    {1'b0, 1'b1, 29'h1A5,         1'b0, 1'b0, 5'd0},  // R3 care bit on remote flag
    {1'b0, 1'b0, 29'h2A5,         1'b0, 1'b0, 5'd0},  // R3 care bit on identifier
    {1'b1, 1'b0, 29'h1ABCDE,      1'b1, 1'b1, 5'd4},  // R2 extended exact
    {1'b1, 1'b1, 29'h1ABCDE,      1'b0, 1'b0, 5'd0},  // R1 extended remote miss
    {1'b1, 1'b1, 29'h123,         1'b1, 1'b1, 5'd5},  // R2 extended remote entry
    {1'b0, 1'b0, 29'h055,         1'b0, 1'b0, 5'd0}   // R5 16-bit-scale bank
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic ext, input logic rtr, input logic [28:0] id);
    @(negedge clk);
    frame_valid = 1; frame_ext = ext; frame_rtr = rtr; frame_id = id;
    @(negedge clk);
    frame_valid = 0;
  endtask

  task automatic expect_res(input string tag, input logic acc, input logic fifo, input int idx);
    chk({tag, " valid"}, int'(result_valid), 1);
    chk({tag, " accept"}, int'(result_accept), int'(acc));
    chk({tag, " fifo"}, int'(result_fifo), int'(fifo));
    chk({tag, " filter"}, int'(result_filter), idx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset valid", int'(result_valid), 0);
    chk("R10 reset accept", int'(result_accept), 0);
    send(1'b0, 1'b0, 29'd0);
    expect_res("R10 empty reject", 1'b0, 1'b0, 0);
    @(negedge clk);
    chk("R9 single pulse", int'(result_valid), 0);

    wr(1, 32'h2);          // R7 ignored: init still clear
    wr(0, 32'h1);
    wr(32, 32'd13 << 21);
    wr(33, 32'd14 << 21);
    wr(34, 32'h100 << 21);
    wr(35, (32'h700 << 21) | 32'h6);
    wr(36, (32'h1ABCDE << 3) | 32'h4);
    wr(37, (32'h123 << 3) | 32'h6);
    wr(40, 32'h055 << 21);
    wr(1, 32'b01010);
    wr(2, 32'b01111);
    wr(3, 32'b00101);
    wr(4, 32'h17);
    wr(0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][37], VEC[i][36], VEC[i][35:7]);
      expect_res($sformatf("R1/R2/R3/R5 vector %0d", i), VEC[i][6], VEC[i][5], int'(VEC[i][4:0]));
    end

    // R7: writes outside init are ignored
    wr(32, 32'd15 << 21);
    wr(3, 32'h0);
    send(1'b0, 1'b0, 29'd15);
    expect_res("R7 guarded reg write", 1'b0, 1'b0, 0);
    send(1'b0, 1'b0, 29'd13);
    expect_res("R7 guarded fifo write", 1'b1, 1'b1, 0);

    // R4: activation writable outside init; catch-all bank 3
    wr(4, 32'h1F);
    send(1'b0, 1'b0, 29'h555);
    expect_res("R4 catch-all active", 1'b1, 1'b0, 6);
    send(1'b0, 1'b0, 29'd13);
    expect_res("R6 lowest wins", 1'b1, 1'b1, 0);
    send(1'b0, 1'b0, 29'h1A5);
    expect_res("R6 mask over catch-all", 1'b1, 1'b0, 2);
    wr(4, 32'h1E);
    send(1'b0, 1'b0, 29'd13);
    expect_res("R4 bank 0 inactive", 1'b1, 1'b0, 6);

    // R8: init suspends matching; R7: writes under init apply
    wr(0, 32'h1);
    send(1'b0, 1'b0, 29'h555);
    expect_res("R8 init reject", 1'b0, 1'b0, 0);
    wr(3, 32'b01000);
    wr(0, 32'h0);
    send(1'b0, 1'b0, 29'h555);
    expect_res("R7 write under init", 1'b1, 1'b1, 6);
    @(negedge clk);
    chk("R9 pulse ends", int'(result_valid), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule